// File: doc/BRIEF.md
# L1 Memory Test-Port Access Engine

This block gives software an indirect path into on-chip L1 data memory. A command word and two 32-bit data registers sit behind a small register port. Writing a nonzero command does two things. It forms an L1 target address by placing selected command bits into fixed address positions over a constant base. It then moves one 64-bit word between the data register pair and a simple memory request port.

Commands that use reserved bits, or that ask for the tag array, are rejected. Each rejection raises a one-cycle error flag and starts no memory traffic. A busy flag covers the whole time from launch to the memory acknowledge. While busy is set, register writes are dropped, so the address and write data stay frozen for the memory side.

The register map is selected by `regSel`:
- 0: base, read-only.
- 1: command.
- 2: data low, bits 31:0 of the word.
- 3: data high, bits 63:32 of the word.

Reads through `regRdData` are combinational.

Top module: `l1_test_port`

## Requirements
- R1: After reset the block is in this state:
  - `busy` and `memReq` are 0, and both error flags are 0.
  - The command and both data registers read 0.
  - The base register reads 0xFF800000.
- R2: A register write to select 0 (base) is ignored; the base still reads 0xFF800000.
- R3: The target address is the base OR'd with these command bits, placed as follows:
  - Command bit 26 goes to address bit 11.
  - Command bit 24 goes to address bit 21.
  - Command bit 23 goes to address bit 15.
  - Command bits 17:16 go to address bits 13:12.
  - Command bits 14 and 10:3 go to the same address bit positions.
- R4: A command with any bit set in mask 0xFA7CB801 pulses `errUndef` for one cycle, in the cycle after the write. It raises no `memReq`.
- R5: A nonzero command with bit 2 (data-array select) clear is a tag-array request. It pulses `errTag` for one cycle, in the cycle after the write, and raises no `memReq`. If the command also uses reserved bits, both flags pulse.
- R6: An accepted valid command with bit 1 (write flag) set raises `memReq` with `memWrite`=1 in the cycle after the write. At the same time `memWrData` equals {data high, data low}.
- R7: An accepted valid command with bit 1 clear raises `memReq` with `memWrite`=0. On `memDone`, `memRdData[31:0]` is loaded into data low and `memRdData[63:0]`'s upper half into data high.
- R8: A command of zero is stored and reads back as 0. It starts no access and raises no error.
- R9: Once raised, `memReq` and `busy` stay high, with `memAddr` and `memWrite` stable, until the cycle on which `memDone` is sampled high. Both drop in the next cycle.
- R10: While `busy` is 1, writes to the command and data registers are ignored. An accepted command, including a rejected one, reads back from select 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 base, 1 command, 2 data low, 3 data high) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regSel` |
| memReq | output | 1 | Memory request, held until `memDone` |
| memWrite | output | 1 | 1 = store data registers, 0 = load into them |
| memAddr | output | 32 | L1 target address |
| memWrData | output | 64 | Store data {data high, data low} |
| memRdData | input | 64 | Load data, valid with `memDone` |
| memDone | input | 1 | Memory acknowledge |
| busy | output | 1 | Transfer pending |
| errUndef | output | 1 | One-cycle pulse: reserved command bits used |
| errTag | output | 1 | One-cycle pulse: tag-array request |

## Verification
The hardest case to reach is a register write that lands while a transfer is outstanding. The bench launches a load and holds `memDone` low. It then writes a new command and new data into every writable register. Before acknowledging, it reads those registers back and checks that `memAddr` has not moved. The address mapping is checked against a per-bit model using commands that set every routed bit, and also single sparse bits.

// File: rtl/l1tp_pkg.sv
package l1tp_pkg;
  localparam int REG_W  = 32;
  localparam int WORD_W = 2 * REG_W;
  localparam int SEL_W  = 2;

  localparam logic [REG_W-1:0] RESERVED_MASK = 32'hFA7C_B801;
  localparam int WRITE_BIT    = 1;
  localparam int DATA_SEL_BIT = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_BASE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DLO  = 2'd2,
    SEL_DHI  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic loadCmd;
    logic loadLo;
    logic loadHi;
    logic launch;
    logic capture;
  } ctrlStrobe_t;

  // Place routed command bits over the base address.
  function automatic logic [REG_W-1:0] mapAddr(input logic [REG_W-1:0] base,
                                               input logic [REG_W-1:0] cmd);
    logic [REG_W-1:0] a;
    a = base;
    a[11]    = a[11]    | cmd[26];
    a[21]    = a[21]    | cmd[24];
    a[15]    = a[15]    | cmd[23];
    a[13:12] = a[13:12] | cmd[17:16];
    a[14]    = a[14]    | cmd[14];
    a[10:3]  = a[10:3]  | cmd[10:3];
    return a;
  endfunction
endpackage

// File: rtl/l1tp_ctrl.sv
module l1tp_ctrl
  import l1tp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [SEL_W-1:0] regSel,
  input  logic [REG_W-1:0] cmdIn,
  input  logic             memDone,
  output ctrlStrobe_t      strobe,
  output logic             busy,
  output logic             memWrite,
  output logic             errUndef,
  output logic             errTag
);
  logic accept, cmdAccept, nonZero, undefHit, tagHit;

  always_comb begin
    accept    = regWrEn && !busy;
    cmdAccept = accept && (regSel == SEL_CMD);
    nonZero   = |cmdIn;
    undefHit  = |(cmdIn & RESERVED_MASK);
    tagHit    = nonZero && !cmdIn[DATA_SEL_BIT];
    strobe.loadCmd = cmdAccept;
    strobe.loadLo  = accept && (regSel == SEL_DLO);
    strobe.loadHi  = accept && (regSel == SEL_DHI);
    strobe.launch  = cmdAccept && nonZero && !undefHit && !tagHit;
    strobe.capture = busy && memDone && !memWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      memWrite <= 1'b0;
      errUndef <= 1'b0;
      errTag   <= 1'b0;
    end else begin
      errUndef <= cmdAccept && undefHit;
      errTag   <= cmdAccept && tagHit;
      if (strobe.launch) begin
        busy     <= 1'b1;
        memWrite <= cmdIn[WRITE_BIT];
      end else if (busy && memDone) begin
        busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/l1tp_datapath.sv
module l1tp_datapath
  import l1tp_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFF80_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [WORD_W-1:0] memRdData,
  output logic [REG_W-1:0]  regRdData,
  output logic [REG_W-1:0]  memAddr,
  output logic [WORD_W-1:0] memWrData
);
  logic [REG_W-1:0] cmdReg, dataLo, dataHi, addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      dataLo  <= '0;
      dataHi  <= '0;
      addrReg <= BASE_ADDR;
    end else begin
      if (strobe.loadCmd) cmdReg <= regWrData;
      if (strobe.launch)  addrReg <= mapAddr(BASE_ADDR, regWrData);
      if (strobe.capture) begin
        dataLo <= memRdData[REG_W-1:0];
        dataHi <= memRdData[WORD_W-1:REG_W];
      end else begin
        if (strobe.loadLo) dataLo <= regWrData;
        if (strobe.loadHi) dataHi <= regWrData;
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_BASE: regRdData = BASE_ADDR;
      SEL_CMD:  regRdData = cmdReg;
      SEL_DLO:  regRdData = dataLo;
      default:  regRdData = dataHi;
    endcase
  end

  assign memAddr   = addrReg;
  assign memWrData = {dataHi, dataLo};
endmodule

// File: rtl/l1_test_port.sv
module l1_test_port
  import l1tp_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'hFF80_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              memReq,
  output logic              memWrite,
  output logic [REG_W-1:0]  memAddr,
  output logic [WORD_W-1:0] memWrData,
  input  logic [WORD_W-1:0] memRdData,
  input  logic              memDone,
  output logic              busy,
  output logic              errUndef,
  output logic              errTag
);
  ctrlStrobe_t strobe;

  l1tp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .cmdIn(regWrData), .memDone(memDone), .strobe(strobe), .busy(busy),
    .memWrite(memWrite), .errUndef(errUndef), .errTag(errTag)
  );

  l1tp_datapath #(.BASE_ADDR(BASE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .regWrData(regWrData), .memRdData(memRdData), .regRdData(regRdData),
    .memAddr(memAddr), .memWrData(memWrData)
  );

  assign memReq = busy;
endmodule

// File: rtl/l1tp_checker.sv
module l1tp_checker (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memWrite,
  input logic [31:0] memAddr,
  input logic        memDone,
  input logic        errUndef,
  input logic        errTag
);
  assert_undef_no_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    errUndef |-> !memReq);

  assert_tag_no_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    errTag |-> !memReq);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memDone) |=> (memReq && $stable(memAddr) && $stable(memWrite)));

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memDone) |=> !memReq);
endmodule

bind l1_test_port l1tp_checker u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memWrite(memWrite),
  .memAddr(memAddr), .memDone(memDone), .errUndef(errUndef), .errTag(errTag)
);

// File: tb/l1_test_port_bench.sv
module l1_test_port_bench;
  localparam logic [31:0] BASE = 32'hFF80_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWrite, busy, errUndef, errTag;
  logic [31:0] memAddr;
  logic [63:0] memWrData;
  logic [63:0] memRdData = '0;
  logic        memDone = 1'b0;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  l1_test_port u_l1_test_port (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memWrite(memWrite), .memAddr(memAddr), .memWrData(memWrData),
    .memRdData(memRdData), .memDone(memDone), .busy(busy),
    .errUndef(errUndef), .errTag(errTag)
  );

  function automatic logic [31:0] expAddr(input logic [31:0] c);
    logic [31:0] a;
    a = BASE;
    a[11] = c[26]; a[21] = c[24]; a[15] = c[23];
    a[13] = c[17]; a[12] = c[16]; a[14] = c[14];
    for (int i = 3; i <= 10; i++) a[i] = c[i];
    return a;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    regSel = sel;
    #1;
    d = regRdData;
  endtask

  task automatic ack(input logic [63:0] d);
    @(negedge clk);
    memDone = 1'b1; memRdData = d;
    @(negedge clk);
    memDone = 1'b0;
  endtask

  task automatic testReset;
    logic [31:0] v;
    check("R1 busy", busy, 0);
    check("R1 memReq", memReq, 0);
    check("R1 errors", {errUndef, errTag}, 0);
    rd(1, v); check("R1 cmd", v, 0);
    rd(2, v); check("R1 dlo", v, 0);
    rd(3, v); check("R1 dhi", v, 0);
    rd(0, v); check("R1 base", v, BASE);
  endtask

  task automatic testBaseWrite;
    logic [31:0] v;
    wr(0, 32'h1234_5678);
    rd(0, v); check("R2 base ignored", v, BASE);
    check("R2 no req", memReq, 0);
  endtask

  task automatic testStore;
    logic [31:0] c;
    c = 32'h0583_45AE;
    wr(2, 32'hCAFE_0001);
    wr(3, 32'hBEEF_0002);
    wr(1, c);
    check("R6 req", memReq, 1);
    check("R6 write", memWrite, 1);
    check("R3 addr full", memAddr, expAddr(c));
    check("R6 wdata", memWrData, 64'hBEEF_0002_CAFE_0001);
    check("R6 no errors", {errUndef, errTag}, 0);
    @(negedge clk);
    check("R9 held", {memReq, busy}, 2'b11);
    ack(64'h0);
    check("R9 drop", {memReq, busy}, 0);
  endtask

  task automatic testLoad;
    logic [31:0] c, v;
    c = 32'h0001_0044;
    wr(1, c);
    check("R7 req", memReq, 1);
    check("R7 read", memWrite, 0);
    check("R3 addr sparse", memAddr, expAddr(c));
    check("R3 addr value", memAddr, 32'hFF80_1040);
    ack(64'h1111_2222_3333_4444);
    check("R9 drop load", memReq, 0);
    rd(2, v); check("R7 low word", v, 32'h3333_4444);
    rd(3, v); check("R7 high word", v, 32'h1111_2222);
  endtask

  task automatic testZero;
    logic [31:0] v;
    wr(1, 32'h0);
    check("R8 no req", memReq, 0);
    check("R8 no error", {errUndef, errTag}, 0);
    rd(1, v); check("R8 stored", v, 0);
  endtask

  task automatic testUndef;
    logic [31:0] v;
    wr(1, 32'h0000_0805);
    check("R4 pulse", errUndef, 1);
    check("R4 no tag", errTag, 0);
    check("R4 no req", memReq, 0);
    rd(1, v); check("R10 rejected stored", v, 32'h0000_0805);
    @(negedge clk);
    check("R4 one cycle", errUndef, 0);
    check("R4 still no req", memReq, 0);
    wr(1, 32'h8000_0000);
    check("R4 and R5 both", {errUndef, errTag}, 2'b11);
  endtask

  task automatic testTag;
    wr(1, 32'h0000_0012);
    check("R5 pulse", errTag, 1);
    check("R5 no undef", errUndef, 0);
    check("R5 no req", memReq, 0);
    @(negedge clk);
    check("R5 one cycle", errTag, 0);
  endtask

  task automatic testBusyIgnore;
    logic [31:0] c, v, a;
    c = 32'h0400_0004;
    wr(1, c);
    a = memAddr;
    check("R3 way bit", a, expAddr(c));
    wr(1, 32'h0000_00FE);
    wr(2, 32'hAAAA_AAAA);
    wr(3, 32'h5555_5555);
    rd(1, v); check("R10 cmd kept", v, c);
    rd(2, v); check("R10 dlo kept", v, 32'h3333_4444);
    rd(3, v); check("R10 dhi kept", v, 32'h1111_2222);
    check("R9 addr stable", memAddr, a);
    check("R9 still busy", busy, 1);
    ack(64'h0BAD_F00D_1234_ABCD);
    rd(2, v); check("R7 after busy", v, 32'h1234_ABCD);
    check("R9 idle", busy, 0);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBaseWrite();
    testStore();
    testLoad();
    testZero();
    testUndef();
    testTag();
    testBusyIgnore();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule